// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects maskable interrupt requests from a fixed set of sources and offers one winning request at a time to the processor. Each source has an 8-bit control register on a simple register bus. The register holds a 3-bit priority level, a pending flag and, for sources driven by an external pin, a trigger-edge select. The lower-numbered sources are pin sources. Their pins pass through a two-flop synchronizer and an edge detector. The remaining sources are internal peripherals, which raise their flag with a one-cycle event pulse.

Each cycle the arbiter looks at every pending source whose level is non-zero. A source is a candidate only when the processor's global enable input is high and the source level is strictly above the processor priority input. The highest level wins, and on a tie the lowest index wins. The result is registered and drives `irq_req`, `irq_src` and `irq_lvl`.

When the processor takes an interrupt, it pulses `ack` with the source index. That pulse clears the source's pending flag and holds the request output low for one cycle, so the next offer comes from the updated flags.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every control register reads 0x00 and `irq_req`, `irq_src` and `irq_lvl` are 0.
- R2: Bits 2..0 of a control register hold the level and read back as written. Bit 3 is the pending flag. In pin-source registers (index < NUM_PIN) bit 4 holds the edge select, and bits 7..5 read 0 and ignore writes. In other registers bits 7..4 read 0 and ignore writes. An address at or above NUM_SRC reads 0x00.
- R3: A register write with bit 3 = 0 clears the pending flag. A write with bit 3 = 1 leaves the flag unchanged, so software can never set it.
- R4: For a pin source, edge select 1 means a rising edge sets the flag and 0 means a falling edge sets it. A pin change applied before clock edge 1 shows in the flag after clock edge 3, and not after edge 2.
- R5: A pin transition opposite to the selected edge never sets the flag.
- R6: A source with level 0 never produces a request, even while its flag is set.
- R7: While `cpu_ie` is 0, `irq_req` is 0 in the following cycle.
- R8: A source qualifies only when its level is strictly greater than `cpu_ipl`.
- R9: Among qualifying sources the highest level wins, and ties go to the lowest index. `irq_src` and `irq_lvl` carry the winner, registered one cycle after the state they reflect.
- R10: An `ack` pulse clears the pending flag of source `ack_src` on the next edge and forces `irq_req` to 0 for that cycle.
- R11: If a hardware set and a software clear or acknowledge hit the same source in the same cycle, the flag ends up set.
- R12: Whenever `irq_req` is 0, `irq_src` and `irq_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W | Register index (source number) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| pin_in | input | NUM_PIN | External interrupt pins, asynchronous |
| periph_evt | input | NUM_SRC-NUM_PIN | Peripheral request pulses, one per internal source |
| cpu_ie | input | 1 | Global interrupt enable from the processor |
| cpu_ipl | input | 3 | Current processor priority level |
| ack | input | 1 | Interrupt acknowledge pulse |
| ack_src | input | IDX_W | Source index being acknowledged |
| irq_req | output | 1 | Request offered to the processor |
| irq_src | output | IDX_W | Index of the winning source |
| irq_lvl | output | 3 | Level of the winning source |

## Verification
The bench aims at the tie between equal levels, where a scan that lets later indices overwrite would report the highest index instead of the lowest. It drives `cpu_ipl` equal to the top pending level, which a non-strict compare would wrongly let through. It puts a peripheral pulse and a clearing write in the same cycle: a design where the clear wins would lose that request. It also checks that a level-0 source with its flag set stays silent, that the wrong pin edge leaves the flag alone, and the exact synchronizer latency. A design with one stage too few would set the flag a cycle early.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W  = 3;
    localparam int CTL_W  = 8;
    localparam int B_PEND = 3;
    localparam int B_POL  = 4;

    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = rise_sel ? (st_q.sync & ~st_q.prev)
                             : (~st_q.sync & st_q.prev);
endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_pkg::*;
#(
    parameter bit HAS_PIN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [4:0]       wdata,
    input  logic             hw_set,
    input  logic             ack_clr,
    output lvl_t             lvl_o,
    output logic             pend_o,
    output logic             pol_o,
    output logic [CTL_W-1:0] ctl_o
);
    typedef struct packed {
        lvl_t lvl;
        logic pend;
        logic pol;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.lvl = wdata[LVL_W-1:0];
            if (HAS_PIN) st_d.pol = wdata[B_POL];
            if (!wdata[B_PEND]) st_d.pend = 1'b0;
        end
        if (ack_clr) st_d.pend = 1'b0;
        if (hw_set)  st_d.pend = 1'b1;
        if (!HAS_PIN) st_d.pol = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctl_o               = '0;
        ctl_o[LVL_W-1:0]    = st_q.lvl;
        ctl_o[B_PEND]       = st_q.pend;
        if (HAS_PIN) ctl_o[B_POL] = st_q.pol;
    end

    assign lvl_o  = st_q.lvl;
    assign pend_o = st_q.pend;
    assign pol_o  = st_q.pol;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            pend,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    input  logic                          ie,
    input  lvl_t                          ipl,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx,
    output lvl_t                          win_lvl
);
    always_comb begin
        hit     = 1'b0;
        idx     = '0;
        win_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (ie && pend[i] && (lvl[i] > ipl) && (lvl[i] > win_lvl)) begin
                hit     = 1'b1;
                idx     = IDX_W'(i);
                win_lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter  int NUM_SRC = 8,
    parameter  int NUM_PIN = 4,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int NUM_PER = NUM_SRC - NUM_PIN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [IDX_W-1:0]   reg_addr,
    input  logic [CTL_W-1:0]   reg_wdata,
    output logic [CTL_W-1:0]   reg_rdata,
    input  logic [NUM_PIN-1:0] pin_in,
    input  logic [NUM_PER-1:0] periph_evt,
    input  logic               cpu_ie,
    input  logic [LVL_W-1:0]   cpu_ipl,
    input  logic               ack,
    input  logic [IDX_W-1:0]   ack_src,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_src,
    output logic [LVL_W-1:0]   irq_lvl
);
    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] src;
        lvl_t             lvl;
    } offer_t;

    logic [NUM_SRC-1:0]            pend;
    logic [NUM_SRC-1:0]            pol;
    logic [NUM_SRC-1:0]            set_hw;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic [NUM_SRC-1:0][CTL_W-1:0] ctl;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic wr_hit, ack_hit;
        assign wr_hit  = reg_wr && (reg_addr == IDX_W'(i));
        assign ack_hit = ack && (ack_src == IDX_W'(i));

        if (i < NUM_PIN) begin : g_pin
            irq_pin_edge u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin      (pin_in[i]),
                .rise_sel (pol[i]),
                .edge_o   (set_hw[i])
            );
        end else begin : g_per
            assign set_hw[i] = periph_evt[i-NUM_PIN];
        end

        irq_src_slot #(.HAS_PIN(i < NUM_PIN)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wdata   (reg_wdata[4:0]),
            .hw_set  (set_hw[i]),
            .ack_clr (ack_hit),
            .lvl_o   (lvl[i]),
            .pend_o  (pend[i]),
            .pol_o   (pol[i]),
            .ctl_o   (ctl[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_addr == IDX_W'(i)) reg_rdata = ctl[i];
        end
    end

    logic             arb_hit;
    logic [IDX_W-1:0] arb_idx;
    lvl_t             arb_lvl;

    irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .pend    (pend),
        .lvl     (lvl),
        .ie      (cpu_ie),
        .ipl     (cpu_ipl),
        .hit     (arb_hit),
        .idx     (arb_idx),
        .win_lvl (arb_lvl)
    );

    offer_t off_d, off_q;

    always_comb begin
        off_d = '0;
        if (!ack && arb_hit) begin
            off_d.req = 1'b1;
            off_d.src = arb_idx;
            off_d.lvl = arb_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end

    assign irq_req = off_q.req;
    assign irq_src = off_q.src;
    assign irq_lvl = off_q.lvl;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
#(
    parameter  int NUM_SRC = 8,
    parameter  int NUM_PIN = 4,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] reg_addr,
    input logic [7:0]       reg_rdata,
    input logic             cpu_ie,
    input logic [2:0]       cpu_ipl,
    input logic             ack,
    input logic             irq_req,
    input logic [IDX_W-1:0] irq_src,
    input logic [2:0]       irq_lvl
);
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_src == '0 && irq_lvl == '0)); // R12

    AST_IE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ie |=> !irq_req); // R7

    AST_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (!irq_req || irq_lvl > $past(cpu_ipl))); // R8

    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq_req); // R10

    AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_lvl != 3'd0); // R6

    AST_PIN_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) < NUM_PIN) |-> reg_rdata[7:5] == 3'b000); // R2

    AST_PER_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) >= NUM_PIN) |-> reg_rdata[7:4] == 4'b0000); // R2
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .cpu_ie    (cpu_ie),
    .cpu_ipl   (cpu_ipl),
    .ack       (ack),
    .irq_req   (irq_req),
    .irq_src   (irq_src),
    .irq_lvl   (irq_lvl)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    localparam int NS = 8;
    localparam int NP = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [IW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NS-NP-1:0] periph_evt = '0;
    logic          cpu_ie = 1'b0;
    logic [2:0]    cpu_ipl = '0;
    logic          ack = 1'b0;
    logic [IW-1:0] ack_src = '0;
    logic          irq_req;
    logic [IW-1:0] irq_src;
    logic [2:0]    irq_lvl;

    always #10 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(NS), .NUM_PIN(NP)) u_prio_irq_ctrl (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [2:0] m_lvl  [NS];
    logic       m_pend [NS];
    logic       m_pol  [NP];
    logic       m_s1 [NP], m_s2 [NP], m_s3 [NP];
    logic          m_req;
    logic [IW-1:0] m_src;
    logic [2:0]    m_lvo;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [IW-1:0] a);
        logic [7:0] r = '0;
        r[2:0] = m_lvl[a];
        r[3]   = m_pend[a];
        if (int'(a) < NP) r[4] = m_pol[a];
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin m_lvl[i] = '0; m_pend[i] = 1'b0; end
        for (int i = 0; i < NP; i++) begin
            m_pol[i] = 1'b0; m_s1[i] = 1'b0; m_s2[i] = 1'b0; m_s3[i] = 1'b0;
        end
        m_req = 1'b0; m_src = '0; m_lvo = '0;
    endtask

    // one clock: model next state, edge, compare at the following negedge
    task automatic tick();
        logic [2:0] nl [NS];
        logic       np [NS];
        logic       npol [NP];
        logic       set;
        logic          nreq = 1'b0;
        logic [IW-1:0] nsrc = '0;
        logic [2:0]    nlvo = '0;
        for (int i = 0; i < NS; i++) begin
            if (cpu_ie && m_pend[i] && m_lvl[i] > cpu_ipl && m_lvl[i] > nlvo) begin
                nreq = 1'b1; nsrc = IW'(i); nlvo = m_lvl[i];
            end
        end
        if (ack) begin nreq = 1'b0; nsrc = '0; nlvo = '0; end
        for (int i = 0; i < NS; i++) begin
            if (i < NP) set = m_pol[i] ? (m_s2[i] & ~m_s3[i]) : (~m_s2[i] & m_s3[i]);
            else        set = periph_evt[i-NP];
            nl[i] = m_lvl[i];
            np[i] = m_pend[i];
            if (reg_wr && reg_addr == IW'(i)) begin
                nl[i] = reg_wdata[2:0];
                if (!reg_wdata[3]) np[i] = 1'b0;
                if (i < NP) npol[i] = reg_wdata[4];
            end else if (i < NP) npol[i] = m_pol[i];
            if (ack && ack_src == IW'(i)) np[i] = 1'b0;
            if (set) np[i] = 1'b1;
        end
        @(posedge clk);
        for (int i = 0; i < NS; i++) begin m_lvl[i] = nl[i]; m_pend[i] = np[i]; end
        for (int i = 0; i < NP; i++) begin
            m_pol[i] = npol[i];
            m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pin_in[i];
        end
        m_req = nreq; m_src = nsrc; m_lvo = nlvo;
        @(negedge clk);
        chk(irq_req == m_req, "R9 irq_req", irq_req, m_req);
        chk(irq_src == m_src, "R9 irq_src", irq_src, m_src);
        chk(irq_lvl == m_lvo, "R9 irq_lvl", irq_lvl, m_lvo);
        chk(reg_rdata == exp_rd(reg_addr), "R2 readback", reg_rdata, exp_rd(reg_addr));
        reg_wr = 1'b0; periph_evt = '0; ack = 1'b0;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = IW'(a); reg_wdata = d;
        tick();
    endtask

    task automatic rd_chk(input int a, input logic [7:0] e, input string tag);
        reg_addr = IW'(a);
        #1;
        chk(reg_rdata == e, tag, reg_rdata, e);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(irq_req == 1'b0 && irq_src == '0 && irq_lvl == '0, "R1 outputs", {irq_req, irq_src, irq_lvl}, 0);
        for (int a = 0; a < NS; a++) rd_chk(a, 8'h00, "R1 register");

        // R2: field masks
        wr(0, 8'hFF); rd_chk(0, 8'h17, "R2 pin reg");
        wr(5, 8'hFF); rd_chk(5, 8'h07, "R2 periph reg");

        // R4: rising edge on pin 0 (edge select 1), exact latency
        pin_in[0] = 1'b1;
        tick(); tick(); rd_chk(0, 8'h17, "R4 not before edge 3");
        tick();          rd_chk(0, 8'h1F, "R4 set after edge 3");

        // R5: pin 1 falling select, rising edge ignored
        wr(1, 8'h03);
        pin_in[1] = 1'b1;
        repeat (5) tick();
        rd_chk(1, 8'h03, "R5 wrong edge ignored");
        pin_in[1] = 1'b0;
        repeat (3) tick();
        rd_chk(1, 8'h0B, "R4 falling edge sets");

        // R3: software cannot set, can clear
        wr(2, 8'h0A); rd_chk(2, 8'h02, "R3 write 1 no set");
        wr(0, 8'h1F); rd_chk(0, 8'h1F, "R3 write 1 keeps");
        wr(0, 8'h17); rd_chk(0, 8'h17, "R3 write 0 clears");

        // R11: hardware set beats same-cycle clear
        wr(4, 8'h03);
        periph_evt[0] = 1'b1; reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h03;
        tick(); rd_chk(4, 8'h0B, "R11 set wins over clear");
        periph_evt[0] = 1'b1; ack = 1'b1; ack_src = 3'd4;
        tick(); rd_chk(4, 8'h0B, "R11 set wins over ack");

        // R7: enable off, nothing offered
        tick(); chk(irq_req == 1'b0, "R7 ie low", irq_req, 0);

        // R9: tie at level 3 between 1 and 4 -> index 1
        cpu_ie = 1'b1; cpu_ipl = 3'd0;
        tick(); tick();
        chk(irq_req && irq_src == 3'd1 && irq_lvl == 3'd3, "R9 tie lowest index", irq_src, 1);
        wr(6, 8'h06); periph_evt[2] = 1'b1; tick(); tick();
        chk(irq_src == 3'd6 && irq_lvl == 3'd6, "R9 highest level", irq_src, 6);

        // R8: strict compare
        cpu_ipl = 3'd6; tick(); tick();
        chk(irq_req == 1'b0, "R8 equal level blocked", irq_req, 0);
        cpu_ipl = 3'd5; tick(); tick();
        chk(irq_req == 1'b1 && irq_src == 3'd6, "R8 above level passes", irq_src, 6);

        // R10: acknowledge
        ack = 1'b1; ack_src = 3'd6;
        tick();
        chk(irq_req == 1'b0, "R10 quiet after ack", irq_req, 0);
        rd_chk(6, 8'h06, "R10 flag cleared");
        cpu_ipl = 3'd0; tick();
        chk(irq_req == 1'b1 && irq_src == 3'd1, "R10 recomputed", irq_src, 1);

        // R6: level 0 with flag set stays silent
        for (int a = 0; a < NS; a++) wr(a, 8'h00);
        periph_evt[3] = 1'b1; tick(); tick(); tick();
        rd_chk(7, 8'h08, "R6 flag set");
        chk(irq_req == 1'b0, "R6 level 0 silent", irq_req, 0);
        wr(7, 8'h0F); tick();
        chk(irq_req == 1'b1 && irq_src == 3'd7 && irq_lvl == 3'd7, "R6 enabled by level", irq_src, 7);

        // R12 and everything else against the model under random stimulus
        void'($urandom(32'h1234_5678));
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                reg_wr = 1'b1; reg_addr = IW'($urandom_range(0, NS-1)); reg_wdata = 8'($urandom);
            end else reg_addr = IW'($urandom_range(0, NS-1));
            if ($urandom_range(0, 9) == 0) pin_in[$urandom_range(0, NP-1)] ^= 1'b1;
            if ($urandom_range(0, 2) == 0) periph_evt = (NS-NP)'($urandom);
            cpu_ie  = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 15) == 0) cpu_ipl = 3'($urandom);
            if (irq_req && $urandom_range(0, 1) == 0) begin ack = 1'b1; ack_src = irq_src; end
            else if ($urandom_range(0, 30) == 0) begin ack = 1'b1; ack_src = IW'($urandom); end
            tick();
            chk(irq_req || (irq_src == '0 && irq_lvl == '0), "R12 idle zero", irq_src, 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule